// File: doc/BRIEF.md
# Tone Steering and Guard Time Validator

This block replaces the resistor-capacitor steering network that follows a tone-pair detector in a telephone keypad receiver. The detector supplies a level that is high while a valid tone pair is present, along with the 4-bit code of that pair. The block decides whether a digit has truly been keyed. A tone must persist for a programmable present guard time before it is accepted. Once accepted, brief dropouts are ignored until the tone has been gone for a programmable absent guard time.

When a tone is accepted, the code is captured into the receive register and a guard output goes high. After a fixed settling delay, the delayed steering flag rises. That rising edge sets a receive-full status bit, which a status read clears. If interrupts are enabled, the same edge also raises an interrupt request. Guard times are counted in clock ticks. The detector level is asynchronous and is resynchronised before any timing starts.

Top module: `tone_steer_validator`

## Requirements
- R1: The detector level passes through a two-flop synchroniser. The first of P consecutive high samples is taken at the third rising clock edge after the level rises, so `guard_o` rises at edge P+2 counted from that change.
- R2: A tone is accepted when the synchronised level has been high on `present_ticks` consecutive clock samples. A value of 0 is treated as 1. On acceptance `guard_o` rises.
- R3: A tone shorter than the present guard time leaves `rx_code_o`, `guard_o`, `steer_o` and `rx_full_o` unchanged.
- R4: On acceptance, the value of `code_i` in that cycle is loaded into `rx_code_o`. The code is bit 3 down to bit 0 as supplied by the detector.
- R5: `steer_o` rises exactly SETTLE_CYC clock edges after `guard_o` rises, with `rx_code_o` unchanged in between.
- R6: While a digit is held, an absence shorter than `absent_ticks` consecutive samples leaves `steer_o`, `guard_o`, `rx_code_o` and `rx_full_o` unchanged. This holds even if the tone returns with a different code.
- R7: After `absent_ticks` consecutive absent samples (0 treated as 1) during hold, `steer_o` and `guard_o` fall on the same edge, and `rx_code_o` keeps the last code. Absence counting starts only once `steer_o` is high.
- R8: Each rising edge of `steer_o` sets `rx_full_o`. A cycle with `status_rd_i` high clears it, but a set in the same cycle wins.
- R9: `irq_o` equals, one edge later, `rx_full_o`'s next value ANDed with `irq_en_i`. It stays low while interrupts are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| est_i | input | 1 | Asynchronous tone-pair-present level from the detector |
| code_i | input | 4 | Decoded tone-pair code, stable while est_i is high |
| present_ticks | input | CW | Present guard time in clock samples |
| absent_ticks | input | CW | Absent guard time in clock samples |
| irq_en_i | input | 1 | Interrupt enable |
| status_rd_i | input | 1 | Status read strobe, clears receive-full |
| rx_code_o | output | 4 | Receive data register |
| guard_o | output | 1 | High from acceptance until release |
| steer_o | output | 1 | Delayed steering flag |
| rx_full_o | output | 1 | Receive-full status |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with a 6-bit guard counter and a 2-cycle settling delay. This keeps every guard time small enough to sweep exhaustively. Present guard times from 1 to 4 and absent guard times from 1 to 3 are crossed with every tone length from one tick up to one past the present guard time. Every dropout length up to and including the absent guard time is also covered. The arithmetic edge positions of acceptance, steering rise and release are checked against the measured ones. The case where a dropout exactly equals the absent guard time, which releases and then re-acquires a new code, is within reach, as is a zero present guard time.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_QUAL   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_HOLD   = 2'd3
  } steer_st_t;
endpackage

// File: rtl/tsv_sync.sv
module tsv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tsv_win.sv
module tsv_win #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);
  logic [CW-1:0] cnt;
  logic [CW:0]   nxt;
  logic [CW:0]   eff;

  assign nxt    = {1'b0, cnt} + 1'b1;
  assign eff    = (limit_i == '0) ? (CW+1)'(1) : {1'b0, limit_i};
  assign last_o = (nxt >= eff);

  always_ff @(posedge clk) begin
    if (rst || clr_i)                 cnt <= '0;
    else if (step_i && (cnt != '1))   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tsv_ctrl.sv
module tsv_ctrl
  import tsv_pkg::*;
#(
  parameter int CW         = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          est_s,
  input  logic [3:0]    code_i,
  input  logic [CW-1:0] present_ticks,
  input  logic [CW-1:0] absent_ticks,
  input  logic          irq_en_i,
  input  logic          status_rd_i,
  output logic [3:0]    rx_code_o,
  output logic          guard_o,
  output logic          steer_o,
  output logic          rx_full_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] SETTLE_LIM = CW'(SETTLE_CYC);

  steer_st_t st_q, st_d;
  logic          clr, step, last;
  logic [CW-1:0] limit;
  logic          accept, rise, release_now;
  logic          full_d;

  always_comb begin
    case (st_q)
      ST_SETTLE: limit = SETTLE_LIM;
      ST_HOLD:   limit = absent_ticks;
      default:   limit = present_ticks;
    endcase
  end

  tsv_win #(.CW(CW)) u_win (
    .clk(clk), .rst(rst), .clr_i(clr), .step_i(step),
    .limit_i(limit), .last_o(last)
  );

  always_comb begin
    st_d        = st_q;
    clr         = 1'b0;
    step        = 1'b0;
    accept      = 1'b0;
    rise        = 1'b0;
    release_now = 1'b0;
    case (st_q)
      ST_IDLE, ST_QUAL: begin
        if (est_s) begin
          if (last) begin
            accept = 1'b1;
            clr    = 1'b1;
            st_d   = ST_SETTLE;
          end else begin
            step = 1'b1;
            st_d = ST_QUAL;
          end
        end else begin
          clr  = 1'b1;
          st_d = ST_IDLE;
        end
      end
      ST_SETTLE: begin
        if (last) begin
          rise = 1'b1;
          clr  = 1'b1;
          st_d = ST_HOLD;
        end else begin
          step = 1'b1;
        end
      end
      default: begin
        if (!est_s) begin
          if (last) begin
            release_now = 1'b1;
            clr         = 1'b1;
            st_d        = ST_IDLE;
          end else begin
            step = 1'b1;
          end
        end else begin
          clr = 1'b1;
        end
      end
    endcase
  end

  assign full_d = rise | (rx_full_o & ~status_rd_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      rx_code_o <= '0;
      guard_o   <= 1'b0;
      steer_o   <= 1'b0;
      rx_full_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      st_q      <= st_d;
      rx_full_o <= full_d;
      irq_o     <= full_d & irq_en_i;
      if (accept) begin
        rx_code_o <= code_i;
        guard_o   <= 1'b1;
      end
      if (rise)        steer_o <= 1'b1;
      if (release_now) begin
        steer_o <= 1'b0;
        guard_o <= 1'b0;
      end
    end
  end

  // R2: acceptance only follows a present sample
  a_r2_accept_on_tone: assert property (@(posedge clk) disable iff (rst)
    $rose(guard_o) |-> $past(est_s));
  // R3: receive register moves only on acceptance
  a_r3_code_hold: assert property (@(posedge clk) disable iff (rst)
    !$rose(guard_o) |-> $stable(rx_code_o));
  // R5: steering rises inside an accepted tone, code already settled
  a_r5_steer_after_guard: assert property (@(posedge clk) disable iff (rst)
    $rose(steer_o) |-> (guard_o && $stable(rx_code_o)));
  // R7: release follows an absent sample and drops guard too
  a_r7_release_absent: assert property (@(posedge clk) disable iff (rst)
    $fell(steer_o) |-> (!guard_o && !$past(est_s)));
  a_r7_guard_with_steer: assert property (@(posedge clk) disable iff (rst)
    $fell(guard_o) |-> $fell(steer_o));
  // R8: every steering rise leaves receive-full set
  a_r8_full_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(steer_o) |-> rx_full_o);
  // R9: no request without enable
  a_r9_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(irq_en_i));
endmodule

// File: rtl/tone_steer_validator.sv
module tone_steer_validator #(
  parameter int CW          = 8,
  parameter int SETTLE_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          est_i,
  input  logic [3:0]    code_i,
  input  logic [CW-1:0] present_ticks,
  input  logic [CW-1:0] absent_ticks,
  input  logic          irq_en_i,
  input  logic          status_rd_i,
  output logic [3:0]    rx_code_o,
  output logic          guard_o,
  output logic          steer_o,
  output logic          rx_full_o,
  output logic          irq_o
);
  logic est_s;

  // R1: resynchronise the detector level
  tsv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(est_i), .q_o(est_s)
  );

  tsv_ctrl #(.CW(CW), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .est_s(est_s), .code_i(code_i),
    .present_ticks(present_ticks), .absent_ticks(absent_ticks),
    .irq_en_i(irq_en_i), .status_rd_i(status_rd_i),
    .rx_code_o(rx_code_o), .guard_o(guard_o), .steer_o(steer_o),
    .rx_full_o(rx_full_o), .irq_o(irq_o)
  );
endmodule

// File: tb/test_tone_steer_validator.sv
module test_tone_steer_validator;
  localparam int CW = 6;
  localparam int S  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          est_i = 1'b0;
  logic [3:0]    code_i = '0;
  logic [CW-1:0] present_ticks = '0;
  logic [CW-1:0] absent_ticks = '0;
  logic          irq_en_i = 1'b0;
  logic          status_rd_i = 1'b0;
  logic [3:0]    rx_code_o;
  logic          guard_o, steer_o, rx_full_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_code = '0;

  always #10 clk = ~clk;

  tone_steer_validator #(.CW(CW), .SETTLE_CYC(S), .SYNC_STAGES(2)) i_tone_steer_validator (
    .clk(clk), .rst(rst), .est_i(est_i), .code_i(code_i),
    .present_ticks(present_ticks), .absent_ticks(absent_ticks),
    .irq_en_i(irq_en_i), .status_rd_i(status_rd_i),
    .rx_code_o(rx_code_o), .guard_o(guard_o), .steer_o(steer_o),
    .rx_full_o(rx_full_o), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_full();
    status_rd_i = 1'b1;
    tick();
    status_rd_i = 1'b0;
    check(rx_full_o == 1'b0, "R8 clear", rx_full_o, 0);
    check(irq_o == 1'b0, "R9 clear", irq_o, 0);
  endtask

  // Tone of L ticks, measure edges of guard rise, steer rise, steer fall
  task automatic tone(input int p, input int a, input int len);
    int g_at, d_at, f_at, total, pe;
    logic [3:0] nc;
    clear_full();
    nc = exp_code + 4'd1;
    code_i = nc;
    est_i = 1'b1;
    g_at = 0; d_at = 0; f_at = 0;
    pe = (p == 0) ? 1 : p;
    total = len + pe + S + a + 8;
    for (int c = 1; c <= total; c++) begin
      tick();
      if (c == len) est_i = 1'b0;
      if (guard_o && g_at == 0) g_at = c;
      if (steer_o && d_at == 0) d_at = c;
      if (!steer_o && d_at != 0 && f_at == 0) f_at = c;
      if (c == pe + S + 2 && len >= pe)
        check(irq_o == irq_en_i, "R9 irq", irq_o, irq_en_i);
    end
    if (len >= pe) begin
      exp_code = nc;
      check(g_at == pe + 2, "R1 R2 guard edge", g_at, pe + 2);
      check(d_at == pe + 2 + S, "R5 steer edge", d_at, pe + 2 + S);
      check(f_at == (((len > pe + S) ? len : pe + S) + a + 2), "R7 release edge",
            f_at, ((len > pe + S) ? len : pe + S) + a + 2);
      check(rx_code_o == exp_code, "R4 code", rx_code_o, exp_code);
      check(rx_full_o == 1'b1, "R8 full", rx_full_o, 1);
    end else begin
      check(g_at == 0 && d_at == 0, "R3 short tone", g_at + d_at, 0);
      check(rx_code_o == exp_code, "R3 code kept", rx_code_o, exp_code);
      check(rx_full_o == 1'b0, "R3 no full", rx_full_o, 0);
    end
  endtask

  // Dropout of D ticks during hold, tone returns with another code
  task automatic dropout(input int p, input int a, input int d);
    logic [3:0] c1, c2;
    bit low_seen;
    c1 = exp_code + 4'd3;
    c2 = c1 + 4'd5;
    code_i = c1;
    est_i = 1'b1;
    for (int c = 0; c < p + S + 4; c++) tick();
    clear_full();
    check(steer_o == 1'b1 && rx_code_o == c1, "R4 held digit", rx_code_o, c1);
    est_i = 1'b0;
    for (int c = 0; c < d; c++) tick();
    code_i = c2;
    est_i = 1'b1;
    low_seen = 1'b0;
    for (int c = 0; c < p + S + 4; c++) begin
      tick();
      if (!steer_o) low_seen = 1'b1;
    end
    if (d < a) begin
      check(!low_seen, "R6 steer held", low_seen, 0);
      check(rx_code_o == c1, "R6 code held", rx_code_o, c1);
      check(rx_full_o == 1'b0, "R6 no new full", rx_full_o, 0);
      exp_code = c1;
    end else begin
      check(low_seen, "R7 release on full gap", low_seen, 1);
      check(rx_code_o == c2, "R4 reacquire", rx_code_o, c2);
      check(rx_full_o == 1'b1, "R8 reacquire full", rx_full_o, 1);
      exp_code = c2;
    end
    est_i = 1'b0;
    for (int c = 0; c < a + 6; c++) tick();
    check(steer_o == 1'b0 && guard_o == 1'b0, "R7 released", steer_o, 0);
    check(rx_code_o == exp_code, "R7 code kept", rx_code_o, exp_code);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    tick(); tick(); tick();
    check(rx_code_o == 4'd0 && guard_o == 1'b0 && steer_o == 1'b0 &&
          rx_full_o == 1'b0 && irq_o == 1'b0, "R8 reset state", rx_code_o, 0);
    rst = 1'b0;
    tick();
    // R2: zero present guard behaves as one
    present_ticks = '0;
    absent_ticks  = CW'(2);
    tone(0, 2, 1);
    for (int p = 1; p <= 4; p++) begin
      for (int a = 1; a <= 3; a++) begin
        present_ticks = CW'(p);
        absent_ticks  = CW'(a);
        irq_en_i = p[0];
        for (int len = 1; len <= p + 1; len++) tone(p, a, len);
        for (int d = 1; d <= a; d++) dropout(p, a, d);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule